// File: doc/BRIEF.md
# PHY Management Serial Controller

This block gives a host register access to the management registers of an external Ethernet PHY over the two-wire MDC/MDIO interface. The host writes one 32-bit command word that packs the target PHY address, the register number, the operation and, for a write, the 16-bit data. The block then runs the whole serial frame: preamble, start, opcode, address, register, turnaround and data. A busy flag in the same word stays set for the length of the frame.

For a read, the block releases MDIO from the turnaround onward. It samples the PHY's reply on rising MDC edges. When the frame ends it sets a read-valid flag and puts the 16-bit result in the low half of the same word. MDC comes from a divider of the system clock. Outgoing bits change on falling MDC edges. A separate small register holds a 5-bit default PHY address for software to use.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset the command word and the PHY-address register both read 0, MDIO is released (`mdio_oe` = 0) and MDC is low.
- R2: The command word layout is data in bits 15:0, PHY address in bits 20:16, register number in bits 25:21 and the operation in bit 26 (1 = read, 0 = write). While a transaction runs, the word reads back the accepted address, register, operation and data.
- R3: Bit 28 (busy) is set from the clock edge that accepts a command until the frame has ended. MDIO is never driven while busy is clear.
- R4: A command written while busy is set is ignored. The fields read back unchanged, and the frame in flight continues unaltered.
- R5: Each frame has 64 bit times sent MSB first: 32 ones, start 01, opcode 10 for a read or 01 for a write, 5 address bits, 5 register bits, a 2-bit turnaround (10 on a write) and 16 data bits.
- R6: On a read, MDIO is released for the last 18 bit times (turnaround and data). At the end of the frame, bit 27 (read-valid) is set, busy is clear, and bits 15:0 hold the 16 bits sampled MSB first.
- R7: Accepting a new command clears read-valid on the same edge.
- R8: MDC has a period of 2*DIV_HALF system clocks. MDIO output changes only where MDC falls, and read data is sampled where MDC rises.
- R9: A write to the PHY-address register changes only its bits 4:0. Bits 31:5 always read 0.
- R10: Command bits 31:29 always read 0, and writing ones into bits 28:27 does not set busy or read-valid by itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_we | input | 1 | Write strobe for the command word |
| cmd_wdata | input | 32 | Command word to write |
| cmd_rdata | output | 32 | Command/status word read-back |
| phyad_we | input | 1 | Write strobe for the PHY-address register |
| phyad_wdata | input | 32 | Value for the PHY-address register |
| phyad_rdata | output | 32 | PHY-address register read-back |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (0 = released) |
| mdio_i | input | 1 | MDIO input from the pad |

## Verification
A wrong bit counter or shift register shows up as a corrupted or shifted serial frame. The bench captures every frame bit at each rising MDC edge and compares it with a frame it builds itself. So an error appears within the same transaction, at most 64 MDC periods later.

A bad busy or read-valid flag shows at the next read-back of the command word. The bench reads that word one clock after each command and again when the frame ends. An output enable left on during a read turnaround would collide with the modelled PHY, and the captured enable pattern shows it on the bit where it happens.

// File: rtl/mdio_mgmt_pkg.sv
// Shared field positions, frame geometry and helpers for the PHY management controller.
// Assumes a 32-bit command word and the standard 64-bit-time management frame.
package mdio_mgmt_pkg;

    localparam int CMD_W      = 32;
    localparam int DATA_W     = 16;
    localparam int FLD_W      = 5;
    localparam int DATA_LSB   = 0;
    localparam int PHY_LSB    = 16;
    localparam int REG_LSB    = 21;
    localparam int OP_BIT     = 26;
    localparam int RVALID_BIT = 27;
    localparam int BUSY_BIT   = 28;

    localparam int PRE_BITS   = 32;
    localparam int HDR_BITS   = 2 + 2 + FLD_W + FLD_W;      // start, opcode, address, register
    localparam int TA_IDX     = PRE_BITS + HDR_BITS;        // first turnaround bit
    localparam int DATA_IDX   = TA_IDX + 2;                 // first data bit
    localparam int FRAME_BITS = DATA_IDX + DATA_W;

    typedef struct packed {
        logic              rd;
        logic [FLD_W-1:0]  regn;
        logic [FLD_W-1:0]  phy;
        logic [DATA_W-1:0] wdata;
    } mgmt_cmd_t;

    // Assemble the serial frame, MSB first; undriven read bits are filled with ones.
    function automatic logic [FRAME_BITS-1:0] build_frame(mgmt_cmd_t c);
        logic [1:0]        op;
        logic [1:0]        ta;
        logic [DATA_W-1:0] d;
        op = c.rd ? 2'b10 : 2'b01;
        ta = c.rd ? 2'b11 : 2'b10;
        d  = c.rd ? {DATA_W{1'b1}} : c.wdata;
        return {{PRE_BITS{1'b1}}, 2'b01, op, c.phy, c.regn, ta, d};
    endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
// MDC generator: divides the system clock by 2*DIV_HALF and flags the
// system-clock cycle on whose closing edge MDC falls or rises.
// Assumes DIV_HALF >= 1; MDC runs freely after reset, starting low.
module mdio_mdc_gen #(
    parameter int DIV_HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic mdc_o,
    output logic fall_evt_o,
    output logic rise_evt_o
);
    localparam int CNT_W = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV_HALF - 1);

    logic [CNT_W-1:0] ph_cnt;
    logic             mdc_q;
    logic             wrap;

    assign wrap       = (ph_cnt == LAST);
    assign fall_evt_o = wrap && mdc_q;
    assign rise_evt_o = wrap && !mdc_q;
    assign mdc_o      = mdc_q;

    // Half-period counter and MDC toggle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_cnt <= '0;
            mdc_q  <= 1'b0;
        end else if (wrap) begin
            ph_cnt <= '0;
            mdc_q  <= ~mdc_q;
        end else begin
            ph_cnt <= ph_cnt + 1'b1;
        end
    end

    // MDC only toggles at the end of a half period (R8).
    assert_mdc_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(mdc_q));

endmodule

// File: rtl/mdio_frame_engine.sv
// Serial frame engine: shifts a 64-bit management frame out on falling MDC,
// releases MDIO during read turnaround and data, and shifts read data in on
// rising MDC. Assumes start_i is only pulsed while the engine is idle.
module mdio_frame_engine
    import mdio_mgmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  mgmt_cmd_t         cmd_i,
    input  logic              fall_evt_i,
    input  logic              rise_evt_i,
    input  logic              mdc_i,
    input  logic              mdio_i,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              done_o,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int IDX_W = $clog2(FRAME_BITS);
    localparam logic [IDX_W-1:0] LAST_POS = IDX_W'(FRAME_BITS - 1);
    localparam logic [IDX_W-1:0] PRE_TA   = IDX_W'(TA_IDX - 1);
    localparam logic [IDX_W-1:0] DATA_POS = IDX_W'(DATA_IDX);

    logic                  run;
    logic                  first;
    logic                  is_rd;
    logic [IDX_W-1:0]      idx;
    logic [FRAME_BITS-1:0] shreg;
    logic [DATA_W-1:0]     rd_sh;

    assign rdata_o = rd_sh;

    // Frame sequencer: loads, shifts out on falling MDC, ends after the last bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run     <= 1'b0;
            first   <= 1'b0;
            is_rd   <= 1'b0;
            idx     <= '0;
            shreg   <= '0;
            mdio_o  <= 1'b1;
            mdio_oe <= 1'b0;
            done_o  <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (start_i && !run) begin
                run   <= 1'b1;
                first <= 1'b1;
                is_rd <= cmd_i.rd;
                idx   <= '0;
                shreg <= build_frame(cmd_i);
            end else if (run && fall_evt_i) begin
                if (first) begin
                    first   <= 1'b0;
                    idx     <= '0;
                    mdio_o  <= shreg[FRAME_BITS-1];
                    mdio_oe <= 1'b1;
                end else if (idx == LAST_POS) begin
                    run     <= 1'b0;
                    mdio_o  <= 1'b1;
                    mdio_oe <= 1'b0;
                    done_o  <= 1'b1;
                end else begin
                    idx     <= idx + 1'b1;
                    shreg   <= {shreg[FRAME_BITS-2:0], 1'b0};
                    mdio_o  <= shreg[FRAME_BITS-2];
                    mdio_oe <= !(is_rd && (idx >= PRE_TA));
                end
            end
        end
    end

    // Read capture: shift in one data bit on each rising MDC of the data phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_sh <= '0;
        end else if (run && !first && rise_evt_i && is_rd && (idx >= DATA_POS)) begin
            rd_sh <= {rd_sh[DATA_W-2:0], mdio_i};
        end
    end

    // Outgoing data moves only together with a falling MDC (R8).
    assert_out_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_o != $past(mdio_o)) |-> $fell(mdc_i));

    // No drive during the turnaround or data phase of a read (R6).
    assert_read_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && is_rd && !first && (idx > PRE_TA)) |-> !mdio_oe);

endmodule

// File: rtl/mdio_mgmt_regs.sv
// Host-visible registers: packed command/status word and the 5-bit default
// PHY-address register. Accepts a command only while idle and launches the engine.
// Assumes done_i is a one-cycle pulse that arrives only while busy.
module mdio_mgmt_regs
    import mdio_mgmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_we,
    input  logic [CMD_W-1:0]  cmd_wdata,
    output logic [CMD_W-1:0]  cmd_rdata,
    input  logic              phyad_we,
    input  logic [CMD_W-1:0]  phyad_wdata,
    output logic [CMD_W-1:0]  phyad_rdata,
    input  logic              done_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic              start_o,
    output mgmt_cmd_t         cmd_o
);
    mgmt_cmd_t        cmd_q;
    logic             busy;
    logic             rvalid;
    logic [FLD_W-1:0] phyad_q;
    logic             accept;

    assign accept = cmd_we && !busy;
    assign cmd_o  = cmd_q;

    // Command acceptance, busy tracking and read-result capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q   <= '0;
            busy    <= 1'b0;
            rvalid  <= 1'b0;
            start_o <= 1'b0;
        end else begin
            start_o <= 1'b0;
            if (accept) begin
                cmd_q.rd    <= cmd_wdata[OP_BIT];
                cmd_q.regn  <= cmd_wdata[REG_LSB +: FLD_W];
                cmd_q.phy   <= cmd_wdata[PHY_LSB +: FLD_W];
                cmd_q.wdata <= cmd_wdata[DATA_LSB +: DATA_W];
                busy        <= 1'b1;
                rvalid      <= 1'b0;
                start_o     <= 1'b1;
            end else if (done_i) begin
                busy <= 1'b0;
                if (cmd_q.rd) begin
                    cmd_q.wdata <= rdata_i;
                    rvalid      <= 1'b1;
                end
            end
        end
    end

    // Default PHY address: only the low five bits are stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phyad_q <= '0;
        end else if (phyad_we) begin
            phyad_q <= phyad_wdata[FLD_W-1:0];
        end
    end

    // Read-back assembly of the command/status word.
    always_comb begin
        cmd_rdata                        = '0;
        cmd_rdata[DATA_LSB +: DATA_W]    = cmd_q.wdata;
        cmd_rdata[PHY_LSB +: FLD_W]      = cmd_q.phy;
        cmd_rdata[REG_LSB +: FLD_W]      = cmd_q.regn;
        cmd_rdata[OP_BIT]                = cmd_q.rd;
        cmd_rdata[RVALID_BIT]            = rvalid;
        cmd_rdata[BUSY_BIT]              = busy;
    end

    // Read-back of the PHY-address register, upper bits zero.
    always_comb begin
        phyad_rdata              = '0;
        phyad_rdata[FLD_W-1:0]   = phyad_q;
    end

    // A command arriving while busy leaves the stored fields alone (R4).
    assert_ignore_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_we && !done_i) |=> $stable(cmd_q) && busy);

    // Accepting a command drops read-valid (R7).
    assert_rvalid_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && !busy) |=> !rvalid);

    // Frame completion releases busy on the next edge (R3).
    assert_busy_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> !busy);

    // Read-valid is never shown together with busy (R6).
    assert_flags_apart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> !busy);

endmodule

// File: rtl/mdio_mgmt_ctrl.sv
// Top level of the PHY management controller: host registers, MDC divider
// and serial frame engine. Assumes an external pad combines mdio_o/mdio_oe/mdio_i.
module mdio_mgmt_ctrl
    import mdio_mgmt_pkg::*;
#(
    parameter int DIV_HALF = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_we,
    input  logic [31:0] cmd_wdata,
    output logic [31:0] cmd_rdata,
    input  logic        phyad_we,
    input  logic [31:0] phyad_wdata,
    output logic [31:0] phyad_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic              start;
    logic              done;
    logic              fall_evt;
    logic              rise_evt;
    logic [DATA_W-1:0] rdata;
    mgmt_cmd_t         cmd;

    mdio_mgmt_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_we      (cmd_we),
        .cmd_wdata   (cmd_wdata),
        .cmd_rdata   (cmd_rdata),
        .phyad_we    (phyad_we),
        .phyad_wdata (phyad_wdata),
        .phyad_rdata (phyad_rdata),
        .done_i      (done),
        .rdata_i     (rdata),
        .start_o     (start),
        .cmd_o       (cmd)
    );

    mdio_mdc_gen #(.DIV_HALF(DIV_HALF)) u_mdc (
        .clk        (clk),
        .rst_n      (rst_n),
        .mdc_o      (mdc),
        .fall_evt_o (fall_evt),
        .rise_evt_o (rise_evt)
    );

    mdio_frame_engine u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .cmd_i      (cmd),
        .fall_evt_i (fall_evt),
        .rise_evt_i (rise_evt),
        .mdc_i      (mdc),
        .mdio_i     (mdio_i),
        .mdio_o     (mdio_o),
        .mdio_oe    (mdio_oe),
        .done_o     (done),
        .rdata_o    (rdata)
    );

    // MDIO is only driven inside a transaction (R3).
    assert_oe_in_txn_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_rdata[BUSY_BIT] |-> !mdio_oe);

endmodule

// File: tb/mdio_mgmt_ctrl_tb.sv
// Self-checking bench: a PHY model answers reads, and each frame is captured
// on rising MDC and compared with a frame built by bench functions.
module mdio_mgmt_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DIV_HALF   = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_we = 1'b0;
    logic [31:0] cmd_wdata = '0;
    logic        phyad_we = 1'b0;
    logic [31:0] phyad_wdata = '0;
    logic        mdio_i = 1'b1;
    logic [31:0] cmd_rdata;
    logic [31:0] phyad_rdata;
    logic        mdc;
    logic        mdio_o;
    logic        mdio_oe;

    int n_chk = 0;
    int n_fail = 0;

    logic [63:0] cap = '0;
    logic [63:0] oev = '0;
    int          k = 0;
    bit          active = 1'b0;
    int          frames = 0;
    logic [15:0] reply = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mdio_mgmt_ctrl #(.DIV_HALF(DIV_HALF)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_we      (cmd_we),
        .cmd_wdata   (cmd_wdata),
        .cmd_rdata   (cmd_rdata),
        .phyad_we    (phyad_we),
        .phyad_wdata (phyad_wdata),
        .phyad_rdata (phyad_rdata),
        .mdc         (mdc),
        .mdio_o      (mdio_o),
        .mdio_oe     (mdio_oe),
        .mdio_i      (mdio_i)
    );

    // Frame capture at each rising MDC.
    always @(posedge mdc) begin
        if (!active && mdio_oe) begin
            active = 1'b1;
            k = 0;
        end
        if (active) begin
            cap[63-k] = mdio_o;
            oev[63-k] = mdio_oe;
            k++;
            if (k == 64) begin
                active = 1'b0;
                frames++;
            end
        end
    end

    // PHY model: drives turnaround zero and reply data after falling MDC.
    always @(negedge mdc) begin
        if (active && k >= 48 && k < 64) mdio_i = reply[63-k];
        else if (active && k == 47)      mdio_i = 1'b0;
        else                             mdio_i = 1'b1;
    end

    function automatic logic [63:0] exp_frame(bit rd, logic [4:0] phy, logic [4:0] rg, logic [15:0] d);
        return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, rg,
                (rd ? 2'b00 : 2'b10), (rd ? 16'h0000 : d)};
    endfunction

    function automatic logic [63:0] exp_oe(bit rd);
        return rd ? {{46{1'b1}}, {18{1'b0}}} : {64{1'b1}};
    endfunction

    function automatic logic [31:0] pack_cmd(bit rd, logic [4:0] phy, logic [4:0] rg, logic [15:0] d);
        return {5'b00000, rd, rg, phy, d};
    endfunction

    function automatic logic [31:0] status_word(bit busy, bit rv, bit rd, logic [4:0] phy,
                                                logic [4:0] rg, logic [15:0] d);
        return {3'b000, busy, rv, rd, rg, phy, d};
    endfunction

    task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_cmd(logic [31:0] w);
        @(negedge clk);
        cmd_we = 1'b1;
        cmd_wdata = w;
        @(negedge clk);
        cmd_we = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (cmd_rdata[28] && n < 5000) begin
            @(negedge clk);
            n++;
        end
        check(n < 5000, "R3 busy clears at frame end", 64'(n), 64'd5000);
    endtask

    // Full transaction with checks on readback, frame bits and result.
    task automatic run_txn(bit rd, logic [4:0] phy, logic [4:0] rg, logic [15:0] d, logic [15:0] rep);
        int f0;
        logic [63:0] m;
        reply = rep;
        f0 = frames;
        wr_cmd(pack_cmd(rd, phy, rg, d));
        check(cmd_rdata == status_word(1, 0, rd, phy, rg, d), "R2 R3 fields and busy after accept",
              64'(cmd_rdata), 64'(status_word(1, 0, rd, phy, rg, d)));
        wait_idle();
        check(frames == f0 + 1, "R5 exactly one frame", 64'(frames), 64'(f0 + 1));
        m = exp_oe(rd);
        check((cap & m) == (exp_frame(rd, phy, rg, d) & m), "R5 frame bits",
              cap & m, exp_frame(rd, phy, rg, d) & m);
        check(oev == m, "R6 MDIO drive pattern", oev, m);
        if (rd)
            check(cmd_rdata == status_word(0, 1, 1, phy, rg, rep), "R6 read result and valid",
                  64'(cmd_rdata), 64'(status_word(0, 1, 1, phy, rg, rep)));
        else
            check(cmd_rdata == status_word(0, 0, 0, phy, rg, d), "R3 write done, flags clear",
                  64'(cmd_rdata), 64'(status_word(0, 0, 0, phy, rg, d)));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        time t0;
        time t1;
        int  f0;
        void'($urandom(32'h5EED_0042));

        // R1: reset state, sampled while reset is held.
        repeat (4) @(negedge clk);
        check(cmd_rdata == 32'h0, "R1 command word reset", 64'(cmd_rdata), 64'h0);
        check(phyad_rdata == 32'h0, "R1 phy address reset", 64'(phyad_rdata), 64'h0);
        check(!mdio_oe && !mdc, "R1 MDIO released and MDC low", {62'h0, mdio_oe, mdc}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R8: MDC period.
        @(posedge mdc);
        t0 = $time;
        @(posedge mdc);
        t1 = $time;
        check((t1 - t0) == 2 * DIV_HALF * CLK_PERIOD, "R8 MDC period",
              64'(t1 - t0), 64'(2 * DIV_HALF * CLK_PERIOD));

        // R9: PHY-address register keeps only five bits.
        @(negedge clk);
        phyad_we = 1'b1;
        phyad_wdata = 32'hFFFF_FFE5;
        @(negedge clk);
        phyad_we = 1'b0;
        check(phyad_rdata == 32'h5, "R9 only low five bits stored", 64'(phyad_rdata), 64'h5);
        phyad_we = 1'b1;
        phyad_wdata = 32'h0000_003F;
        @(negedge clk);
        phyad_we = 1'b0;
        check(phyad_rdata == 32'h1F, "R9 bit 5 dropped", 64'(phyad_rdata), 64'h1F);

        // R5 R2: directed writes at field extremes.
        run_txn(0, 5'd0, 5'd0, 16'h0000, 16'h0);
        run_txn(0, 5'd31, 5'd31, 16'hFFFF, 16'h0);
        run_txn(0, 5'd10, 5'd21, 16'h8001, 16'h0);

        // R6: directed reads.
        run_txn(1, 5'd31, 5'd0, 16'h0, 16'hA5C3);
        run_txn(1, 5'd0, 5'd31, 16'h0, 16'h0001);

        // R7: new command clears read-valid at once.
        wr_cmd(pack_cmd(0, 5'd3, 5'd4, 16'h5A5A));
        check(cmd_rdata[27] == 1'b0, "R7 read-valid cleared by new command", 64'(cmd_rdata[27]), 64'h0);
        wait_idle();

        // R4: command while busy is ignored.
        reply = 16'h3C96;
        f0 = frames;
        wr_cmd(pack_cmd(1, 5'd7, 5'd9, 16'h0));
        repeat (30) @(negedge clk);
        wr_cmd(pack_cmd(0, 5'd20, 5'd2, 16'h1111));
        check(cmd_rdata == status_word(1, 0, 1, 5'd7, 5'd9, 16'h0), "R4 fields kept while busy",
              64'(cmd_rdata), 64'(status_word(1, 0, 1, 5'd7, 5'd9, 16'h0)));
        wait_idle();
        check(frames == f0 + 1, "R4 one frame only", 64'(frames), 64'(f0 + 1));
        check((cap & exp_oe(1)) == (exp_frame(1, 5'd7, 5'd9, 16'h0) & exp_oe(1)), "R4 frame unaltered",
              cap & exp_oe(1), exp_frame(1, 5'd7, 5'd9, 16'h0) & exp_oe(1));
        check(cmd_rdata == status_word(0, 1, 1, 5'd7, 5'd9, 16'h3C96), "R4 original read completes",
              64'(cmd_rdata), 64'(status_word(0, 1, 1, 5'd7, 5'd9, 16'h3C96)));

        // R10: upper bits written as ones do not stick.
        wr_cmd(32'hF800_0000 | pack_cmd(0, 5'd3, 5'd4, 16'h1234));
        check(cmd_rdata == status_word(1, 0, 0, 5'd3, 5'd4, 16'h1234), "R10 reserved bits and flags",
              64'(cmd_rdata), 64'(status_word(1, 0, 0, 5'd3, 5'd4, 16'h1234)));
        wait_idle();
        check(cmd_rdata[31:27] == 5'b0, "R10 flags clear after write", 64'(cmd_rdata[31:27]), 64'h0);

        // R5 R6: random transactions.
        for (int i = 0; i < 12; i++) begin
            run_txn(1'($urandom), 5'($urandom), 5'($urandom), 16'($urandom), 16'($urandom));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule